// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and date as packed binary-coded-decimal fields: a four-digit sub-second count, seconds, minutes, 24-hour hours, day of month, month and a two-digit year (2000 to 2099). It advances from a one-cycle `tick` enable that pulses once per period of a 32.768 kHz reference. A prescaler turns every 32 ticks into one sub-second step, so there are 1024 sub-second steps per second. The day rollover follows the length of the current month, including leap Februaries.

A host sets the time in two stages. First it writes fields one at a time into a staging buffer, which leaves the running time untouched. Then it pulses `commit_req`. One cycle later all staged fields replace the live fields together, and the prescaler restarts from zero. Alongside the live fields, the block gives a one-cycle strobe each time the sub-second, second, minute, hour or day field increments. Other logic can use these strobes as time-base events.

Top module: `bcd_rtc_core`

## Requirements
- R1: While `rst` is high, and after it is released, the live fields read sub-second 0000, seconds 00, minutes 00, hours 00, day 01, month 01, year 00. All strobes and `commit_pending` read 0.
- R2: The sub-second field advances once for every 32 cycles with `tick` high, whether or not those cycles are consecutive. Cycles with `tick` low do not count. `stb_sub` is high for exactly the one cycle in which the new value first appears.
- R3: The sub-second field is four BCD digits: bit 12 is the thousands digit, bits 11:8 the hundreds, bits 7:4 the tens and bits 3:0 the units. It counts 0000 to 1023 and then wraps to 0000. On that wrap the seconds increment and `stb_sec` pulses.
- R4: Seconds and minutes count 00 to 59 in BCD, with the tens digit in bits 6:4 and the units in bits 3:0. A wrap from 59 increments the next field. `stb_min` pulses when the minutes increment.
- R5: Hours count 00 to 23 in BCD, with the tens digit in bits 5:4. A wrap from 23 to 00 increments the day. `stb_hour` pulses when the hours increment, and `stb_day` pulses when the day advances.
- R6: The last day of a month is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends on 28, or on 29 when the year value is divisible by 4. When the day advances past the last day, it becomes 01 and the month increments. The day uses BCD bits 5:4 for tens.
- R7: When the day advances past the last day of month 12, the month becomes 01 and the year increments. Year 99 wraps to 00. Month uses bit 4 for tens, and year uses bits 7:4 for tens.
- R8: A cycle with `stage_we` high stores `stage_data` into one staged field chosen by `stage_sel`: 0 sub-second, 1 seconds, 2 minutes, 3 hours, 4 day, 5 month, 6 year. Code 7 changes nothing. Staging writes never change the live outputs.
- R9: A cycle with `commit_req` high makes `commit_pending` read 1 after the next edge. At the following edge every live field takes its staged value, and `commit_pending` clears by itself unless the request is repeated.
- R10: In the cycle that performs the transfer, a `tick` is dropped: no strobe follows, and the prescaler restarts its 32-tick count from zero.
- R11: Strobes nest. `stb_sec` implies `stb_sub`, `stb_min` implies `stb_sec`, `stb_hour` implies `stb_min`, and `stb_day` implies `stb_hour`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable per 32.768 kHz period |
| stage_we | input | 1 | Staging buffer write enable |
| stage_sel | input | 3 | Staged field select |
| stage_data | input | 13 | BCD value for the selected field (low bits used) |
| commit_req | input | 1 | Request to transfer the staging buffer into the live time |
| commit_pending | output | 1 | Transfer will happen at the next edge |
| subsec | output | 13 | Live sub-second count, BCD |
| sec | output | 7 | Live seconds, BCD |
| minute | output | 7 | Live minutes, BCD |
| hour | output | 6 | Live hours, BCD |
| day | output | 6 | Live day of month, BCD |
| month | output | 5 | Live month, BCD |
| year | output | 8 | Live two-digit year, BCD |
| stb_sub | output | 1 | Sub-second increment strobe |
| stb_sec | output | 1 | Seconds increment strobe |
| stb_min | output | 1 | Minutes increment strobe |
| stb_hour | output | 1 | Hours increment strobe |
| stb_day | output | 1 | Day increment strobe |

## Verification
Every result appears one edge after the inputs that cause it. When the 32nd `tick` is sampled, all carried fields and their strobes change at that same edge. A staged write changes no output at all. A `commit_req` shows as `commit_pending` after one edge, and the live fields show the staged values after the second edge. The bench model applies the same sampled inputs at each rising edge, and the bench compares every output at the following falling edge. No check therefore needs a per-case delay. Named checks for reset, staging and the commit cycle are placed at those same falling edges, counted from the stimulus.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [12:0] sub;
    logic [6:0]  sec;
    logic [6:0]  min;
    logic [5:0]  hour;
    logic [5:0]  day;
    logic [4:0]  mon;
    logic [7:0]  year;
  } rtc_time_t;

  typedef enum logic [2:0] {
    SEL_SUB  = 3'd0,
    SEL_SEC  = 3'd1,
    SEL_MIN  = 3'd2,
    SEL_HOUR = 3'd3,
    SEL_DAY  = 3'd4,
    SEL_MON  = 3'd5,
    SEL_YEAR = 3'd6,
    SEL_NONE = 3'd7
  } stage_sel_e;

  localparam rtc_time_t TIME_RESET = '{sub: 13'h0000, sec: 7'h00, min: 7'h00,
                                       hour: 6'h00, day: 6'h01, mon: 5'h01,
                                       year: 8'h00};

  // Leap test on a BCD year 00..99: divisible by 4
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4])
      return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else
      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  // Last valid BCD day of a BCD month (R6)
  function automatic logic [5:0] last_day(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_bcd_inc.sv
// Width-exact BCD +1; the top digit may be narrower than 4 bits.
module rtc_bcd_inc #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] nxt
);
  localparam int ND   = (W + 3) / 4;
  localparam int TOPW = W - 4 * (ND - 1);

  logic [ND-1:0] cin;
  assign cin[0] = 1'b1;

  for (genvar g = 0; g < ND; g++) begin : g_dig
    localparam int DW = (g == ND - 1) ? TOPW : 4;
    logic [DW-1:0] d;
    logic          nine;
    assign d    = val[4*g +: DW];
    assign nine = (4'(d) == 4'd9);
    assign nxt[4*g +: DW] = cin[g] ? (nine ? '0 : d + DW'(1)) : d;
    if (g < ND - 1) begin : g_carry
      assign cin[g+1] = cin[g] & nine;
    end
  end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic adv
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign adv = tick & ~clear & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick)    cnt <= adv ? '0 : cnt + CW'(1);
  end

  AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);  // R2
  AST_PRESC_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick && !clear |=> cnt == $past(cnt));  // R2
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic        adv,
  input  logic [12:0] ld_sub,
  input  logic [6:0]  ld_sec,
  input  logic [6:0]  ld_min,
  input  logic [5:0]  ld_hour,
  output logic [12:0] sub,
  output logic [6:0]  sec,
  output logic [6:0]  min,
  output logic [5:0]  hour,
  output logic        stb_sub,
  output logic        stb_sec,
  output logic        stb_min,
  output logic        stb_hour,
  output logic        day_carry
);
  logic [12:0] sub_inc;
  logic [6:0]  sec_inc, min_inc;
  logic [5:0]  hour_inc;
  logic        sub_wrap, sec_wrap, min_wrap, hour_wrap;

  rtc_bcd_inc #(.W(13)) u_inc_sub  (.val(sub),  .nxt(sub_inc));
  rtc_bcd_inc #(.W(7))  u_inc_sec  (.val(sec),  .nxt(sec_inc));
  rtc_bcd_inc #(.W(7))  u_inc_min  (.val(min),  .nxt(min_inc));
  rtc_bcd_inc #(.W(6))  u_inc_hour (.val(hour), .nxt(hour_inc));

  assign sub_wrap  = (sub  == 13'h1023);
  assign sec_wrap  = (sec  == 7'h59);
  assign min_wrap  = (min  == 7'h59);
  assign hour_wrap = (hour == 6'h23);
  assign day_carry = adv & sub_wrap & sec_wrap & min_wrap & hour_wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      sub <= '0; sec <= '0; min <= '0; hour <= '0;
      stb_sub <= 1'b0; stb_sec <= 1'b0; stb_min <= 1'b0; stb_hour <= 1'b0;
    end else if (load) begin
      sub <= ld_sub; sec <= ld_sec; min <= ld_min; hour <= ld_hour;
      stb_sub <= 1'b0; stb_sec <= 1'b0; stb_min <= 1'b0; stb_hour <= 1'b0;
    end else begin
      stb_sub  <= adv;
      stb_sec  <= adv & sub_wrap;
      stb_min  <= adv & sub_wrap & sec_wrap;
      stb_hour <= adv & sub_wrap & sec_wrap & min_wrap;
      if (adv) begin
        sub <= sub_wrap ? '0 : sub_inc;
        if (sub_wrap) begin
          sec <= sec_wrap ? '0 : sec_inc;
          if (sec_wrap) begin
            min <= min_wrap ? '0 : min_inc;
            if (min_wrap) hour <= hour_wrap ? '0 : hour_inc;
          end
        end
      end
    end
  end

  AST_SUB_CHANGES: assert property (@(posedge clk) disable iff (rst)
    stb_sub |-> sub != $past(sub));  // R2
  AST_SUB_WRAP: assert property (@(posedge clk) disable iff (rst)
    stb_sec |-> sub == 13'h0000);  // R3
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    stb_min |-> sec == 7'h00);  // R4
  AST_MIN_WRAP: assert property (@(posedge clk) disable iff (rst)
    stb_hour |-> min == 7'h00);  // R4
  AST_STB_NEST: assert property (@(posedge clk) disable iff (rst)
    (stb_sec |-> stb_sub) and (stb_min |-> stb_sec) and (stb_hour |-> stb_min));  // R11
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       carry,
  input  logic [5:0] ld_day,
  input  logic [4:0] ld_mon,
  input  logic [7:0] ld_year,
  output logic [5:0] day,
  output logic [4:0] month,
  output logic [7:0] year,
  output logic       stb_day
);
  logic [5:0] day_inc, last;
  logic [4:0] mon_inc;
  logic [7:0] year_inc;

  rtc_bcd_inc #(.W(6)) u_inc_day  (.val(day),   .nxt(day_inc));
  rtc_bcd_inc #(.W(5)) u_inc_mon  (.val(month), .nxt(mon_inc));
  rtc_bcd_inc #(.W(8)) u_inc_year (.val(year),  .nxt(year_inc));

  assign last = last_day(month, year);

  always_ff @(posedge clk) begin
    if (rst) begin
      day <= TIME_RESET.day; month <= TIME_RESET.mon; year <= TIME_RESET.year;
      stb_day <= 1'b0;
    end else if (load) begin
      day <= ld_day; month <= ld_mon; year <= ld_year;
      stb_day <= 1'b0;
    end else begin
      stb_day <= carry;
      if (carry) begin
        if (day >= last) begin
          day <= 6'h01;
          if (month >= 5'h12) begin
            month <= 5'h01;
            year  <= (year == 8'h99) ? 8'h00 : year_inc;
          end else begin
            month <= mon_inc;
          end
        end else begin
          day <= day_inc;
        end
      end
    end
  end

  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (rst)
    stb_day && day == 6'h01 |-> month != $past(month));  // R6
  AST_YEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    stb_day && day == 6'h01 && month == 5'h01 |-> year != $past(year));  // R7
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int PRESC_DIV = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        stage_we,
  input  logic [2:0]  stage_sel,
  input  logic [12:0] stage_data,
  input  logic        commit_req,
  output logic        commit_pending,
  output logic [12:0] subsec,
  output logic [6:0]  sec,
  output logic [6:0]  minute,
  output logic [5:0]  hour,
  output logic [5:0]  day,
  output logic [4:0]  month,
  output logic [7:0]  year,
  output logic        stb_sub,
  output logic        stb_sec,
  output logic        stb_min,
  output logic        stb_hour,
  output logic        stb_day
);
  rtc_time_t staged;
  logic      adv, day_carry;

  // Staging buffer: writes never reach the live counters (R8)
  always_ff @(posedge clk) begin
    if (rst) begin
      staged <= TIME_RESET;
    end else if (stage_we) begin
      case (stage_sel_e'(stage_sel))
        SEL_SUB:  staged.sub  <= stage_data;
        SEL_SEC:  staged.sec  <= stage_data[6:0];
        SEL_MIN:  staged.min  <= stage_data[6:0];
        SEL_HOUR: staged.hour <= stage_data[5:0];
        SEL_DAY:  staged.day  <= stage_data[5:0];
        SEL_MON:  staged.mon  <= stage_data[4:0];
        SEL_YEAR: staged.year <= stage_data[7:0];
        default:  ;
      endcase
    end
  end

  // Commit flag: set by request, consumed by the transfer one edge later (R9)
  always_ff @(posedge clk) begin
    if (rst) commit_pending <= 1'b0;
    else     commit_pending <= commit_req;
  end

  rtc_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst(rst), .clear(commit_pending), .tick(tick), .adv(adv)
  );

  rtc_time_chain u_time (
    .clk(clk), .rst(rst), .load(commit_pending), .adv(adv),
    .ld_sub(staged.sub), .ld_sec(staged.sec), .ld_min(staged.min), .ld_hour(staged.hour),
    .sub(subsec), .sec(sec), .min(minute), .hour(hour),
    .stb_sub(stb_sub), .stb_sec(stb_sec), .stb_min(stb_min), .stb_hour(stb_hour),
    .day_carry(day_carry)
  );

  rtc_date_chain u_date (
    .clk(clk), .rst(rst), .load(commit_pending), .carry(day_carry),
    .ld_day(staged.day), .ld_mon(staged.mon), .ld_year(staged.year),
    .day(day), .month(month), .year(year), .stb_day(stb_day)
  );

  AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (rst)
    commit_pending |=> subsec == $past(staged.sub) && day == $past(staged.day)
                       && year == $past(staged.year));  // R9
  AST_TICK_DROP: assert property (@(posedge clk) disable iff (rst)
    commit_pending |=> !stb_sub && !stb_day);  // R10
  AST_DAY_NEST: assert property (@(posedge clk) disable iff (rst)
    stb_day |-> stb_hour);  // R11
endmodule

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int DIV        = 32;

  logic        clk = 1'b0, rst = 1'b1, tick = 1'b0, stage_we = 1'b0, commit_req = 1'b0;
  logic [2:0]  stage_sel = '0;
  logic [12:0] stage_data = '0;
  logic        commit_pending, stb_sub, stb_sec, stb_min, stb_hour, stb_day;
  logic [12:0] subsec;
  logic [6:0]  sec, minute;
  logic [5:0]  hour, day;
  logic [4:0]  month;
  logic [7:0]  year;

  bcd_rtc_core #(.PRESC_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .tick(tick), .stage_we(stage_we), .stage_sel(stage_sel),
    .stage_data(stage_data), .commit_req(commit_req), .commit_pending(commit_pending),
    .subsec(subsec), .sec(sec), .minute(minute), .hour(hour), .day(day),
    .month(month), .year(year), .stb_sub(stb_sub), .stb_sec(stb_sec),
    .stb_min(stb_min), .stb_hour(stb_hour), .stb_day(stb_day)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  n_cmp = 0, n_bad = 0;
  bit  done = 0, armed = 0;

  // Behavioural reference state (binary integers)
  int m_presc, m_sub, m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_pend;
  int s_sub, s_sec, s_min, s_hr, s_day, s_mon, s_yr;
  bit e_sub, e_sec, e_min, e_hr, e_day;

  function automatic int bcd(input int v);
    return ((v/1000)%10)*4096 + ((v/100)%10)*256 + ((v/10)%10)*16 + v%10;
  endfunction
  function automatic int unbcd(input int b);
    return ((b>>12)&15)*1000 + ((b>>8)&15)*100 + ((b>>4)&15)*10 + (b&15);
  endfunction
  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_presc = 0; m_sub = 0; m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0;
      s_sub = 0; s_sec = 0; s_min = 0; s_hr = 0; s_day = 1; s_mon = 1; s_yr = 0;
      m_pend = 0; {e_sub, e_sec, e_min, e_hr, e_day} = '0; armed = 1;
    end else begin
      {e_sub, e_sec, e_min, e_hr, e_day} = '0;
      if (m_pend != 0) begin
        m_sub = s_sub; m_sec = s_sec; m_min = s_min; m_hr = s_hr;
        m_day = s_day; m_mon = s_mon; m_yr = s_yr; m_presc = 0;
      end else if (tick) begin
        if (m_presc == DIV - 1) begin
          m_presc = 0; m_sub++; e_sub = 1;
          if (m_sub == 1024) begin
            m_sub = 0; m_sec++; e_sec = 1;
            if (m_sec == 60) begin
              m_sec = 0; m_min++; e_min = 1;
              if (m_min == 60) begin
                m_min = 0; m_hr++; e_hr = 1;
                if (m_hr == 24) begin
                  m_hr = 0; m_day++; e_day = 1;
                  if (m_day > mdays(m_mon, m_yr)) begin
                    m_day = 1; m_mon++;
                    if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
                  end
                end
              end
            end
          end
        end else m_presc++;
      end
      if (stage_we) begin
        case (stage_sel)
          3'd0: s_sub = unbcd(int'(stage_data));
          3'd1: s_sec = unbcd(int'(stage_data[6:0]));
          3'd2: s_min = unbcd(int'(stage_data[6:0]));
          3'd3: s_hr  = unbcd(int'(stage_data[5:0]));
          3'd4: s_day = unbcd(int'(stage_data[5:0]));
          3'd5: s_mon = unbcd(int'(stage_data[4:0]));
          3'd6: s_yr  = unbcd(int'(stage_data[7:0]));
          default: ;
        endcase
      end
      m_pend = commit_req ? 1 : 0;
    end
  end

  // Compare every output on every falling edge
  always @(negedge clk) begin
    if (armed && !rst && !done) begin
      check("R3 subsec",     int'(subsec), bcd(m_sub));
      check("R4 sec",        int'(sec),    bcd(m_sec));
      check("R4 minute",     int'(minute), bcd(m_min));
      check("R5 hour",       int'(hour),   bcd(m_hr));
      check("R6 day",        int'(day),    bcd(m_day));
      check("R7 month",      int'(month),  bcd(m_mon));
      check("R7 year",       int'(year),   bcd(m_yr));
      check("R2 stb_sub",    int'(stb_sub),  int'(e_sub));
      check("R3 stb_sec",    int'(stb_sec),  int'(e_sec));
      check("R4 stb_min",    int'(stb_min),  int'(e_min));
      check("R5 stb_hour",   int'(stb_hour), int'(e_hr));
      check("R5 stb_day",    int'(stb_day),  int'(e_day));
      check("R9 pending",    int'(commit_pending), m_pend);
      check("R11 strobe nesting", int'((stb_sec & ~stb_sub) | (stb_min & ~stb_sec)
                                     | (stb_hour & ~stb_min) | (stb_day & ~stb_hour)), 0);
    end
  end

  task automatic stage_write(input int sel, input int val);
    stage_we = 1'b1; stage_sel = 3'(sel); stage_data = 13'(val);
    @(negedge clk);
    stage_we = 1'b0;
  endtask

  task automatic set_time(input int sb, input int s, input int mi, input int h,
                          input int d, input int mo, input int y);
    stage_write(0, bcd(sb)); stage_write(1, bcd(s)); stage_write(2, bcd(mi));
    stage_write(3, bcd(h));  stage_write(4, bcd(d)); stage_write(5, bcd(mo));
    stage_write(6, bcd(y));
    commit_req = 1'b1;
    @(negedge clk);
    commit_req = 1'b0;
    check("R9 commit flag set one edge after request", int'(commit_pending), 1);
    @(negedge clk);
    check("R9 staged sub-second transferred", int'(subsec), bcd(sb));
    check("R9 staged day transferred", int'(day), bcd(d));
    check("R10 tick dropped on transfer cycle", int'(stb_sub), 0);
    check("R9 commit flag self-clears", int'(commit_pending), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset subsec", int'(subsec), 0);
    check("R1 reset sec", int'(sec), 0);
    check("R1 reset hour", int'(hour), 0);
    check("R1 reset day", int'(day), 1);
    check("R1 reset month", int'(month), 1);
    check("R1 reset year", int'(year), 0);
    check("R1 reset strobes", int'({stb_sub, stb_sec, stb_min, stb_hour, stb_day}), 0);
    check("R1 reset pending", int'(commit_pending), 0);
    rst = 1'b0;

    // Continuous ticks: full sub-second wrap into seconds (R2, R3)
    tick = 1'b1;
    repeat (DIV * 1024 + 200) @(negedge clk);
    // Sparse ticks: one in three cycles (R2)
    for (int k = 0; k < 3000; k++) begin
      tick = (k % 3 == 0);
      @(negedge clk);
    end

    // Staging writes leave live time untouched; code 7 ignored (R8)
    tick = 1'b0;
    @(negedge clk);
    begin
      int snap_sub, snap_sec;
      snap_sub = int'(subsec); snap_sec = int'(sec);
      stage_write(1, 'h33);
      stage_write(7, 'h1fff);
      check("R8 live subsec unchanged by staging", int'(subsec), snap_sub);
      check("R8 live sec unchanged by staging", int'(sec), snap_sec);
    end

    // Boundary rollovers with ticks running during commit (R6, R7, R10)
    tick = 1'b1;
    set_time(1020, 59, 59, 23, 28, 2, 24); repeat (200) @(negedge clk);
    check("R6 leap February reaches 29", int'(day), 'h29);
    set_time(1020, 59, 59, 23, 29, 2, 24); repeat (200) @(negedge clk);
    check("R6 29 Feb rolls to March", int'(month), 'h03);
    set_time(1020, 59, 59, 23, 28, 2, 23); repeat (200) @(negedge clk);
    check("R6 common February rolls to March", int'(month), 'h03);
    set_time(1020, 59, 59, 23, 28, 2, 0);  repeat (200) @(negedge clk);
    check("R6 year 00 February reaches 29", int'(day), 'h29);
    set_time(1020, 59, 59, 23, 30, 4, 51); repeat (200) @(negedge clk);
    check("R6 April ends on 30", int'(month), 'h05);
    set_time(1020, 59, 59, 23, 30, 1, 51); repeat (200) @(negedge clk);
    check("R6 January reaches 31", int'(day), 'h31);
    set_time(1020, 59, 59, 23, 30, 11, 7); repeat (200) @(negedge clk);
    check("R6 November rolls to December", int'(month), 'h12);
    set_time(1020, 59, 59, 23, 31, 12, 99); repeat (200) @(negedge clk);
    check("R7 year 99 wraps to 00", int'(year), 0);
    check("R7 month 12 wraps to 01", int'(month), 1);
    set_time(1020, 59, 59, 23, 31, 12, 38); repeat (200) @(negedge clk);
    check("R7 year increments", int'(year), 'h39);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule